// File: doc/BRIEF.md
# Stereo PDM Channel Receiver with Decimation to PCM

The block receives a two-wire pulse-density link: one clock line, and one data line that carries two audio channels in turns. The left-channel bit is valid at the rising edge of the link clock and the right-channel bit at the falling edge. A static select pin chooses which channel is kept. The block oversamples the link clock with its own faster system clock, finds the edges, and captures the chosen channel's bits. It maps each bit to +1 or -1 and reduces the stream by 128 with a third-order integrator/comb filter. The result is a 16-bit signed PCM sample for every 128 captured bits.

An optional first-order DC-blocking high-pass stage follows the decimator. A control pin switches it in or out without changing the output latency. Samples leave through a valid/ready port. A sample stays on `pcm_data`, with `pcm_valid` high, until the consumer raises `pcm_ready`. If a newer sample is finished before that, it replaces the waiting one, so back-pressure never stalls the filter. With `pcm_ready` held high, each sample is a one-cycle `pcm_valid` pulse.

A watchdog on the link clock raises a loss flag when the clock stops. All filter state is then cleared and the output is forced to zero. After the clock returns, the block settles again before it delivers new samples.

Top module: `pdm_rx_decim`

## Requirements
- R1: With `chan_sel`=0, the bit captured at each rising edge of `pdm_clk` is the one decoded. The level on `pdm_data` around falling edges has no effect on the samples.
- R2: With `chan_sel`=1, the bit captured at each falling edge of `pdm_clk` is the one decoded. The level around rising edges has no effect.
- R3: A captured 1 counts as +1 and a 0 as -1. Every 128 captured bits give one sample, equal to the third-order box-filter sum of the bit values (kernel = three 128-tap unit boxes convolved), aligned on the 128th bit. All-ones input gives 32767, all-zeros gives -32768 and a 1010... stream gives 0.
- R4: The filter sum is divided by 64 with floor rounding (arithmetic right shift by 6), then clamped to the range -32768..32767.
- R5: After reset, and after each loss of the link clock, the first three decimated samples are discarded. `chan_locked` is low until the third one has been discarded and stays high while the link is alive. `pcm_valid` is never high while `chan_locked` is low.
- R6: With `hpf_en`=1, each delivered sample is y[n] = x[n] - x[n-1] + y[n-1] - floor(y[n-1]/1024), clamped to 16 bits. x[-1] and y[-1] are zero after reset or restart. The filter state keeps updating while the filter is bypassed.
- R7: With `hpf_en`=0, the delivered sample equals the decimator sample x[n], with the same latency as the filtered path.
- R8: While `pcm_valid`=1 and `pcm_ready`=0, `pcm_valid` stays high and `pcm_data` does not change, unless a newer sample replaces it or the link is lost. A sample is consumed in a cycle where both are high.
- R9: After 256 system clocks without any `pdm_clk` edge, `clk_lost` goes high, `pcm_valid` and `pcm_data` are forced to zero and all filter state is cleared. The next edge clears `clk_lost`, and bit counting starts again from that edge.
- R10: During and directly after reset, `pcm_valid`, `pcm_data`, `chan_locked` and `clk_lost` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be several times faster than `pdm_clk` |
| rst_n | input | 1 | Active-low synchronous reset |
| pdm_clk | input | 1 | Link clock, asynchronous to `clk` |
| pdm_data | input | 1 | Link data, two channels interleaved |
| chan_sel | input | 1 | 0 keeps the rising-edge (left) channel, 1 keeps the falling-edge (right) channel |
| hpf_en | input | 1 | 1 switches the DC-blocking filter into the path |
| pcm_data | output | 16 | Signed PCM sample |
| pcm_valid | output | 1 | `pcm_data` holds a sample not yet consumed |
| pcm_ready | input | 1 | Consumer accepts the sample in this cycle |
| chan_locked | output | 1 | Decimator has settled on the selected channel |
| clk_lost | output | 1 | No link-clock edge seen for 256 system clocks |

## Verification
The bench drives the unselected channel with the inverse of the selected one. A design that used the wrong edge would then produce mirror-image samples, and one that used both edges would produce near-zero samples. Full-scale ones hit the single positive code that needs clamping, so a missing clamp shows up as a wrap to -32768. An off-by-one in the filter's bit alignment, or in the count of settling samples, shows up as wrong values or extra samples in the ramp and restart phases. The bench also stalls the consumer across the arrival of a sample to catch an output that moves or drops while it waits. It stops the link clock to catch filter state left standing through a restart.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

  localparam int PCM_W = 16;

  typedef logic signed [PCM_W-1:0] pcm_t;

  // Clamp a wide signed value into the PCM range.
  function automatic pcm_t sat_pcm(input logic signed [31:0] v);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = (32'sd1 <<< (PCM_W - 1)) - 32'sd1;
    lo = -hi - 32'sd1;
    if (v > hi) return pcm_t'(hi);
    if (v < lo) return pcm_t'(lo);
    return pcm_t'(v);
  endfunction

endpackage

// File: rtl/pdm_edge_capture.sv
module pdm_edge_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int LOST_LIMIT  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdm_clk,
  input  logic pdm_data,
  input  logic chan_sel,
  output logic bit_stb,
  output logic bit_val,
  output logic clk_lost
);

  localparam int CW = $clog2(LOST_LIMIT);

  logic [SYNC_STAGES:0]   clk_sh;
  logic [SYNC_STAGES-1:0] dat_sh;
  logic [CW-1:0]          idle_cnt;

  logic clk_now, clk_prev, dat_now;
  logic rise, fall, any_edge, take;

  assign clk_now  = clk_sh[SYNC_STAGES-1];
  assign clk_prev = clk_sh[SYNC_STAGES];
  assign dat_now  = dat_sh[SYNC_STAGES-1];
  assign rise     = clk_now & ~clk_prev;
  assign fall     = ~clk_now & clk_prev;
  assign any_edge = rise | fall;
  assign take     = chan_sel ? fall : rise;

  // Clock and data pass through matching synchronizer depth so the data
  // sample seen with an edge is the level at that edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sh <= '0;
      dat_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[SYNC_STAGES-1:0], pdm_clk};
      dat_sh <= {dat_sh[SYNC_STAGES-2:0], pdm_data};
    end
  end

  // Bit strobe is one cycle behind the edge so the loss flag is already
  // clear when the first bit after a restart reaches the filter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_stb <= take;
      bit_val <= dat_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      clk_lost <= 1'b0;
    end else if (any_edge) begin
      idle_cnt <= '0;
      clk_lost <= 1'b0;
    end else if (idle_cnt == CW'(LOST_LIMIT - 1)) begin
      clk_lost <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_LOST_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_lost) |-> $past(idle_cnt) == CW'(LOST_LIMIT - 1)); // R9

  AST_EDGE_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    any_edge |=> !clk_lost); // R9

endmodule

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim import pdm_rx_pkg::*; #(
  parameter int ORDER = 3,
  parameter int RATIO = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_stb,
  input  logic in_bit,
  output logic out_stb,
  output pcm_t out_pcm
);

  localparam int RW    = $clog2(RATIO);
  localparam int ACC_W = ORDER * RW + 2;
  localparam int SHIFT = ORDER * RW - (PCM_W - 1);

  typedef logic signed [ACC_W-1:0] acc_t;

  acc_t          integ_q [ORDER];
  acc_t          integ_d [ORDER];
  acc_t          dly_q   [ORDER];
  acc_t          comb_in [ORDER+1];
  acc_t          x_in;
  acc_t          snap_q;
  acc_t          res_q;
  logic [RW-1:0] phase_q;
  logic          comb_go;
  logic          last_bit;

  assign x_in     = in_bit ? acc_t'(1) : acc_t'(-1);
  assign last_bit = in_stb && (phase_q == RW'(RATIO - 1));

  // Integrators chained combinationally so each stage sees this bit.
  for (genvar k = 0; k < ORDER; k++) begin : g_integ
    if (k == 0) begin : g_first
      assign integ_d[k] = integ_q[k] + x_in;
    end else begin : g_next
      assign integ_d[k] = integ_q[k] + integ_d[k-1];
    end
  end

  assign comb_in[0] = snap_q;
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign comb_in[k+1] = comb_in[k] - dly_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < ORDER; k++) integ_q[k] <= '0;
      phase_q <= '0;
      snap_q  <= '0;
      comb_go <= 1'b0;
    end else begin
      comb_go <= last_bit;
      if (in_stb) begin
        for (int k = 0; k < ORDER; k++) integ_q[k] <= integ_d[k];
        phase_q <= phase_q + 1'b1;
      end
      if (last_bit) snap_q <= integ_d[ORDER-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
      res_q   <= '0;
      out_stb <= 1'b0;
    end else begin
      out_stb <= comb_go;
      if (comb_go) begin
        for (int k = 0; k < ORDER; k++) dly_q[k] <= comb_in[k];
        res_q <= comb_in[ORDER];
      end
    end
  end

  assign out_pcm = sat_pcm(32'(res_q >>> SHIFT));

  AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |=> !out_stb); // R3

endmodule

// File: rtl/pdm_dc_block.sv
module pdm_dc_block import pdm_rx_pkg::*; #(
  parameter int STATE_W    = 20,
  parameter int POLE_SHIFT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic in_stb,
  input  pcm_t x_in,
  output logic out_stb,
  output pcm_t y_out
);

  typedef logic signed [STATE_W-1:0] st_t;

  st_t x_prev, y_prev, x_ext, y_next;

  assign x_ext  = st_t'(x_in);
  assign y_next = x_ext - x_prev + y_prev - (y_prev >>> POLE_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x_prev  <= '0;
      y_prev  <= '0;
      y_out   <= '0;
      out_stb <= 1'b0;
    end else begin
      out_stb <= in_stb;
      if (in_stb) begin
        x_prev <= x_ext;
        y_prev <= y_next;
        y_out  <= en ? sat_pcm(32'(y_next)) : x_in;
      end
    end
  end

  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && !en && !clr) |=> (y_out == $past(x_in))); // R7

endmodule

// File: rtl/pdm_rx_decim.sv
module pdm_rx_decim import pdm_rx_pkg::*; #(
  parameter int DECIM          = 128,
  parameter int CIC_ORDER      = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int LOST_LIMIT     = 256,
  parameter int SETTLE_COUNT   = 3,
  parameter int HPF_STATE_W    = 20,
  parameter int HPF_POLE_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdm_clk,
  input  logic              pdm_data,
  input  logic              chan_sel,
  input  logic              hpf_en,
  output logic signed [15:0] pcm_data,
  output logic              pcm_valid,
  input  logic              pcm_ready,
  output logic              chan_locked,
  output logic              clk_lost
);

  localparam int SW = $clog2(SETTLE_COUNT + 1);

  logic          bit_stb, bit_val;
  logic          cic_stb, hpf_stb, pass_stb, settled;
  pcm_t          cic_pcm, hpf_pcm, hold_data;
  logic          hold_valid;
  logic [SW-1:0] settle_cnt;

  pdm_edge_capture #(
    .SYNC_STAGES (SYNC_STAGES),
    .LOST_LIMIT  (LOST_LIMIT)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdm_clk  (pdm_clk),
    .pdm_data (pdm_data),
    .chan_sel (chan_sel),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .clk_lost (clk_lost)
  );

  pdm_cic_decim #(
    .ORDER (CIC_ORDER),
    .RATIO (DECIM)
  ) u_cic (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clk_lost),
    .in_stb  (bit_stb),
    .in_bit  (bit_val),
    .out_stb (cic_stb),
    .out_pcm (cic_pcm)
  );

  // Discard the first samples while the comb delays fill.
  assign settled  = (settle_cnt == SW'(SETTLE_COUNT));
  assign pass_stb = cic_stb && settled;

  always_ff @(posedge clk) begin
    if (!rst_n || clk_lost) begin
      settle_cnt <= '0;
    end else if (cic_stb && !settled) begin
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  pdm_dc_block #(
    .STATE_W    (HPF_STATE_W),
    .POLE_SHIFT (HPF_POLE_SHIFT)
  ) u_hpf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clk_lost),
    .en      (hpf_en),
    .in_stb  (pass_stb),
    .x_in    (cic_pcm),
    .out_stb (hpf_stb),
    .y_out   (hpf_pcm)
  );

  // Single holding register: newest sample wins, filter never waits.
  always_ff @(posedge clk) begin
    if (!rst_n || clk_lost) begin
      hold_data  <= '0;
      hold_valid <= 1'b0;
    end else if (hpf_stb) begin
      hold_data  <= hpf_pcm;
      hold_valid <= 1'b1;
    end else if (hold_valid && pcm_ready) begin
      hold_valid <= 1'b0;
    end
  end

  assign pcm_valid   = hold_valid && !clk_lost;
  assign pcm_data    = clk_lost ? '0 : hold_data;
  assign chan_locked = settled && !clk_lost;

  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |-> (!pcm_valid && pcm_data == '0)); // R9

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !pcm_ready) |=>
      (clk_lost || $past(hpf_stb) || (pcm_valid && $stable(pcm_data)))); // R8

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> chan_locked); // R5

endmodule

// File: tb/test_pdm_rx_decim.sv
module test_pdm_rx_decim;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdm_clk = 1'b0;
  logic pdm_data = 1'b0;
  logic chan_sel = 1'b0;
  logic hpf_en = 1'b0;
  logic pcm_ready = 1'b1;
  logic signed [15:0] pcm_data;
  logic pcm_valid, chan_locked, clk_lost;

  pdm_rx_decim i_pdm_rx_decim (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdm_clk     (pdm_clk),
    .pdm_data    (pdm_data),
    .chan_sel    (chan_sel),
    .hpf_en      (hpf_en),
    .pcm_data    (pcm_data),
    .pcm_valid   (pcm_valid),
    .pcm_ready   (pcm_ready),
    .chan_locked (chan_locked),
    .clk_lost    (clk_lost)
  );

  always #10 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    n_got   = 0;
  string req_tag = "R10";
  int    kern [382];
  int    xq   [$];
  int    expq [$];
  int    hx_prev = 0;
  int    hy_prev = 0;
  int    sd_acc  = 0;
  int    bit_ctr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Kernel of three chained 128-sample moving sums.
  task automatic build_kernel();
    int k1 [255];
    for (int i = 0; i < 255; i++) k1[i] = 0;
    for (int i = 0; i < 128; i++)
      for (int j = 0; j < 128; j++) k1[i+j] += 1;
    for (int i = 0; i < 382; i++) kern[i] = 0;
    for (int i = 0; i < 255; i++)
      for (int j = 0; j < 128; j++) kern[i+j] += k1[i];
  endtask

  task automatic model_restart();
    xq.delete();
    hx_prev = 0;
    hy_prev = 0;
  endtask

  task automatic model_push(input bit b);
    int n, m, acc, hx, hp;
    xq.push_back(b ? 1 : -1);
    if (xq.size() % 128 == 0) begin
      n = xq.size() / 128 - 1;
      m = 128 * n + 127;
      acc = 0;
      for (int j = 0; j < 382; j++)
        if (m - j >= 0) acc += kern[j] * xq[m-j];
      if (n >= 3) begin
        hx = sat16(acc >>> 6);
        hp = hx - hx_prev + hy_prev - (hy_prev >>> 10);
        hx_prev = hx;
        hy_prev = hp;
        expq.push_back(hpf_en ? sat16(hp) : hx);
      end
    end
  endtask

  task automatic drive_pair(input bit l, input bit r);
    pdm_data = l;
    #40 pdm_clk = 1'b1;
    #40 pdm_data = r;
    #40 pdm_clk = 1'b0;
    #40;
  endtask

  // kind: 0 ones, 1 zeros, 2 alternating, 3 three-in-four ones, 4 ramp via first-order modulator
  task automatic drive_groups(input int kind, input int groups);
    bit b;
    int level, ph;
    for (int g = 0; g < groups; g++) begin
      for (int i = 0; i < 128; i++) begin
        case (kind)
          0: b = 1'b1;
          1: b = 1'b0;
          2: b = (bit_ctr % 2 == 0);
          3: b = (bit_ctr % 4 != 3);
          default: begin
            ph = bit_ctr % 512;
            level = (ph < 256) ? (ph * 6 - 768) : (768 - (ph - 256) * 6);
            b = (sd_acc >= 0);
            sd_acc += level - (b ? 1024 : -1024);
          end
        endcase
        bit_ctr++;
        if (chan_sel) drive_pair(~b, b);
        else          drive_pair(b, ~b);
        model_push(b);
      end
    end
  endtask

  task automatic quiet(input int cycles);
    repeat (cycles) @(posedge clk);
    #5;
  endtask

  task automatic phase_end(input string tag);
    quiet(20);
    check(expq.size() == 0, tag, expq.size(), 0);
    expq.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && pcm_valid && pcm_ready) begin
      n_got++;
      if (expq.size() == 0) begin
        check(1'b0, req_tag, int'(pcm_data), 99999);
      end else begin
        int e;
        e = expq.pop_front();
        check(int'(pcm_data) == e, req_tag, int'(pcm_data), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10: watchdog expired, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int g0, held;
    bit held_seen, stall_bad;
    build_kernel();
    repeat (4) @(posedge clk);
    #5;
    // R10: reset state
    check(pcm_valid == 1'b0, "R10", pcm_valid, 0);
    check(pcm_data == 16'sd0, "R10", int'(pcm_data), 0);
    check(chan_locked == 1'b0, "R10", chan_locked, 0);
    check(clk_lost == 1'b0, "R10", clk_lost, 0);
    @(posedge clk); #5 rst_n = 1'b1;
    model_restart();

    // R1 and R3: full-scale ones on the rising-edge channel, clamped
    req_tag = "R3";
    drive_groups(0, 8);
    phase_end("R3");
    check(n_got == 5, "R5", n_got, 5);
    check(chan_locked == 1'b1, "R5", chan_locked, 1);
    req_tag = "R1";
    drive_groups(2, 6);
    phase_end("R1");
    req_tag = "R4";
    drive_groups(3, 6);
    phase_end("R4");

    // R6: high-pass switched in on a DC stream
    hpf_en = 1'b1;
    req_tag = "R6";
    drive_groups(3, 8);
    phase_end("R6");

    // R7: bypass with a ramp
    hpf_en = 1'b0;
    req_tag = "R7";
    drive_groups(4, 6);
    phase_end("R7");

    // R8: consumer stalls across the arrival of one sample
    req_tag = "R8";
    held = 0; held_seen = 1'b0; stall_bad = 1'b0;
    g0 = n_got;
    fork
      drive_groups(3, 3);
      begin
        wait (n_got != g0);
        repeat (500) @(posedge clk);
        #3 pcm_ready = 1'b0;
        repeat (900) begin
          @(negedge clk);
          if (pcm_valid) begin
            if (!held_seen) begin
              held = int'(pcm_data);
              held_seen = 1'b1;
            end else if (int'(pcm_data) != held) stall_bad = 1'b1;
          end else if (held_seen) stall_bad = 1'b1;
        end
        @(posedge clk);
        #3 pcm_ready = 1'b1;
      end
    join
    check(held_seen && !stall_bad, "R8", int'(stall_bad), 0);
    phase_end("R8");

    // R9: link clock stops
    req_tag = "R9";
    quiet(300);
    check(clk_lost == 1'b1, "R9", clk_lost, 1);
    check(pcm_valid == 1'b0, "R9", pcm_valid, 0);
    check(pcm_data == 16'sd0, "R9", int'(pcm_data), 0);
    check(chan_locked == 1'b0, "R5", chan_locked, 0);
    model_restart();
    g0 = n_got;
    drive_groups(1, 2);
    quiet(20);
    check(clk_lost == 1'b0, "R9", clk_lost, 0);
    check(chan_locked == 1'b0, "R5", chan_locked, 0);
    drive_groups(1, 4);
    phase_end("R9");
    check(n_got - g0 == 3, "R5", n_got - g0, 3);

    // R2: falling-edge channel after a fresh reset
    @(posedge clk); #5 rst_n = 1'b0;
    chan_sel = 1'b1;
    quiet(4);
    check(chan_locked == 1'b0, "R10", chan_locked, 0);
    rst_n = 1'b1;
    model_restart();
    req_tag = "R2";
    g0 = n_got;
    drive_groups(4, 8);
    phase_end("R2");
    check(n_got - g0 == 5, "R2", n_got - g0, 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule